// File: doc/BRIEF.md
# Infrared Controller FIFO with Threshold Service Requests

This block holds the byte queue between the host and the serial infrared line of an infrared communication controller, and tells the host when the queue needs attention. One 32-entry, 8-bit FIFO serves whichever direction is selected. In transmit mode the host fills the queue and the line side drains it, so service is wanted while occupancy is below the programmed threshold. In receive mode the line side fills the queue and the host drains it, so service is wanted once occupancy reaches the threshold.

The same threshold feeds both service paths. With DMA disabled, the request appears as a level interrupt. With DMA enabled, the interrupt is held low and a DMA request is raised instead, with a programmable active polarity. The request is dropped on an acknowledge cycle that leaves the queue on the satisfied side of the threshold, or at once on a terminal-count acknowledge. In receive mode, a timeout counter flags bytes left below the threshold. It fires after 32 bit times with no new byte, so the host can collect the leftovers without DMA.

Top module: `irfifo_dma`

## Requirements
- R1: Bytes leave the FIFO in the order they were pushed. `pop_data` always presents the oldest stored byte. `count` gives the occupancy, from 0 to 32, and `full` is high at 32.
- R2: A push while the FIFO is full and no pop is in the same cycle is dropped. It leaves `count` and the stored bytes unchanged and sets `overrun` on the next cycle. `overrun` stays set until the block goes idle.
- R3: While the FIFO is empty, `pop_data` is 0. A pop on an empty FIFO leaves `count` at 0.
- R4: Receive mode is `rx_en`=1 with `tx_en`=0. In this mode, service is wanted when `count` is non-zero and `count` >= `thresh`.
- R5: Transmit mode is `tx_en`=1, and it takes priority over `rx_en`. In this mode, service is wanted when `count` < `thresh`.
- R6: With `dma_en`=0, `irq` equals the service-wanted condition in the same cycle and the DMA request stays inactive. With `dma_en`=1, `irq` is 0 and the DMA request becomes active on the cycle after service is wanted.
- R7: The polarity select works as follows: `dreq_pol`=0 makes `dreq` active low, and `dreq_pol`=1 makes it active high. The inactive level is the opposite one.
- R8: Once active, the DMA request stays active, even if service is no longer wanted. It goes inactive on the cycle after a `dack` cycle whose resulting occupancy no longer wants service.
- R9: A cycle with both `dack` and `tc` high forces the DMA request inactive from the next cycle on. The request stays inactive until service has stopped being wanted and is then wanted again.
- R10: When both `tx_en` and `rx_en` are 0, the block is idle: `irq` is 0, the DMA request is inactive, `rx_timeout` is 0 and `overrun` is cleared.
- R11: In receive mode, while 0 < `count` < `thresh`, `rx_timeout` rises 32 × `bit_period` clock cycles after the last push. A push or a pop clears it on the next cycle.
- R12: After reset the FIFO is empty, `overrun`, `irq` and `rx_timeout` are 0, and the DMA request is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit mode select |
| rx_en | input | 1 | Receive mode select |
| dma_en | input | 1 | Route service requests to the DMA handshake instead of `irq` |
| dreq_pol | input | 1 | DMA request polarity, 1 = active high |
| thresh | input | 6 | Occupancy threshold shared by both request paths |
| bit_period | input | 16 | Clock cycles per line bit, must be at least 1 |
| push | input | 1 | Write `push_data` into the FIFO |
| push_data | input | 8 | Byte to store |
| pop | input | 1 | Remove the oldest byte |
| pop_data | output | 8 | Oldest stored byte, 0 when empty |
| dack | input | 1 | DMA acknowledge strobe |
| tc | input | 1 | Terminal count, qualified by `dack` |
| count | output | 6 | FIFO occupancy |
| full | output | 1 | FIFO holds 32 bytes |
| overrun | output | 1 | Sticky dropped-push flag |
| irq | output | 1 | Level service request when DMA is off |
| dreq | output | 1 | DMA request at the selected polarity |
| rx_timeout | output | 1 | Receive leftovers have aged 32 bit times |

## Verification
The threshold logic is tried in both directions. Receive mode steps occupancy up across the threshold and back, while transmit mode starts from empty and fills past it, so a swapped comparison or an off-by-one in either direction is exposed. The DMA path is tried under each polarity. One case removes bytes without an acknowledge, which separates the held request from a plain level. Another case gives an acknowledge with terminal count while the queue still wants service, which separates the forced release from the threshold-driven release. The FIFO is filled to 32 and then overfilled, and the drained contents show whether the extra byte was dropped. The timeout is sampled just before and just after its nominal expiry, and again after a refreshing push.

// File: rtl/irfifo_pkg.sv
package irfifo_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TX   = 2'd1,
        MODE_RX   = 2'd2
    } ir_mode_e;

    // Transmit wins when both enables are set.
    function automatic ir_mode_e pick_mode(input logic tx, input logic rx);
        if (tx)      return MODE_TX;
        else if (rx) return MODE_RX;
        else         return MODE_IDLE;
    endfunction

endpackage

// File: rtl/irfifo_store.sv
module irfifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nx,
    output logic          full,
    output logic          overrun
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic                     ovr;
    } store_t;

    store_t st_d, st_q;
    logic   do_push, do_pop, is_full, is_empty;

    always_comb begin
        is_full  = (st_q.cnt == CW'(DEPTH));
        is_empty = (st_q.cnt == '0);
        do_pop   = pop && !is_empty;
        do_push  = push && (!is_full || do_pop);

        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (idle)
            st_d.ovr = 1'b0;
        else if (push && !do_push)
            st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_data = (st_q.cnt != '0) ? st_q.mem[st_q.rp] : '0;
    assign count    = st_q.cnt;
    assign count_nx = st_d.cnt;
    assign full     = (st_q.cnt == CW'(DEPTH));
    assign overrun  = st_q.ovr;

endmodule

// File: rtl/irfifo_req.sv
module irfifo_req
    import irfifo_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ir_mode_e      mode,
    input  logic [CW-1:0] thresh,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] count_nx,
    input  logic          dma_en,
    input  logic          dreq_pol,
    input  logic          dack,
    input  logic          tc,
    output logic          irq,
    output logic          dreq,
    output logic          req_act
);

    typedef struct packed {
        logic req;
        logic tc_block;
    } req_t;

    req_t rq_d, rq_q;
    logic want_now, want_after, dma_on, tc_hit;

    function automatic logic wants(input ir_mode_e m, input logic [CW-1:0] c,
                                   input logic [CW-1:0] t);
        case (m)
            MODE_RX: return (c != '0) && (c >= t);
            MODE_TX: return (c < t);
            default: return 1'b0;
        endcase
    endfunction

    always_comb begin
        want_now   = wants(mode, count, thresh);
        want_after = wants(mode, count_nx, thresh);
        dma_on     = dma_en && (mode != MODE_IDLE);
        tc_hit     = dack && tc;

        rq_d = rq_q;
        if (!dma_on)
            rq_d.tc_block = 1'b0;
        else if (tc_hit)
            rq_d.tc_block = 1'b1;
        else if (!want_now)
            rq_d.tc_block = 1'b0;

        if (!dma_on || tc_hit)
            rq_d.req = 1'b0;
        else if (rq_q.req)
            rq_d.req = !(dack && !want_after);
        else
            rq_d.req = want_now && !rq_q.tc_block;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign irq     = !dma_en && want_now;
    assign req_act = rq_q.req;
    assign dreq    = dreq_pol ? rq_q.req : !rq_q.req;

endmodule

// File: rtl/irfifo_rxtmo.sv
module irfifo_rxtmo
    import irfifo_pkg::*;
#(
    parameter int CW   = 6,
    parameter int BP_W = 16,
    localparam int TW  = BP_W + 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  ir_mode_e        mode,
    input  logic [CW-1:0]   count,
    input  logic [CW-1:0]   thresh,
    input  logic [BP_W-1:0] bit_period,
    input  logic            push,
    input  logic            pop,
    output logic            timeout
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          flag;
    } tmo_t;

    tmo_t tm_d, tm_q;
    logic          running, touched;
    logic [TW-1:0] last_tick;

    always_comb begin
        // 4 characters of 8 bits each
        last_tick = {bit_period, 5'b0} - 1'b1;
        running   = (mode == MODE_RX) && (count != '0) && (count < thresh);
        touched   = push || pop;

        tm_d = tm_q;
        if (touched || !running)
            tm_d.cnt = '0;
        else if (!tm_q.flag)
            tm_d.cnt = tm_q.cnt + 1'b1;

        if (touched || !running)
            tm_d.flag = 1'b0;
        else if (tm_q.cnt == last_tick)
            tm_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign timeout = tm_q.flag;

endmodule

// File: rtl/irfifo_dma.sv
module irfifo_dma
    import irfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int BP_W  = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_en,
    input  logic            rx_en,
    input  logic            dma_en,
    input  logic            dreq_pol,
    input  logic [CW-1:0]   thresh,
    input  logic [BP_W-1:0] bit_period,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    output logic [DW-1:0]   pop_data,
    input  logic            dack,
    input  logic            tc,
    output logic [CW-1:0]   count,
    output logic            full,
    output logic            overrun,
    output logic            irq,
    output logic            dreq,
    output logic            rx_timeout
);

    ir_mode_e      mode;
    logic [CW-1:0] count_nx;
    logic          req_act;

    assign mode = pick_mode(tx_en, rx_en);

    irfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (mode == MODE_IDLE),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .count     (count),
        .count_nx  (count_nx),
        .full      (full),
        .overrun   (overrun)
    );

    irfifo_req #(.CW(CW)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .thresh   (thresh),
        .count    (count),
        .count_nx (count_nx),
        .dma_en   (dma_en),
        .dreq_pol (dreq_pol),
        .dack     (dack),
        .tc       (tc),
        .irq      (irq),
        .dreq     (dreq),
        .req_act  (req_act)
    );

    irfifo_rxtmo #(.CW(CW), .BP_W(BP_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .count      (count),
        .thresh     (thresh),
        .bit_period (bit_period),
        .push       (push),
        .pop        (pop),
        .timeout    (rx_timeout)
    );

endmodule

// File: rtl/irfifo_dma_chk.sv
module irfifo_dma_chk #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_en,
    input logic          rx_en,
    input logic          dma_en,
    input logic          push,
    input logic          pop,
    input logic          dack,
    input logic          tc,
    input logic [CW-1:0] count,
    input logic [DW-1:0] pop_data,
    input logic          overrun,
    input logic          irq,
    input logic          rx_timeout,
    input logic          req_act
);

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_empty_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (pop_data == '0));

    assert_full_push_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == CW'(DEPTH)) && push && !pop && (tx_en || rx_en)) |=> overrun);

    assert_dma_masks_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |-> !irq);

    assert_idle_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en) |-> !irq);

    assert_idle_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en) |=> (!req_act && !rx_timeout));

    assert_tc_drops_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && tc) |=> !req_act);

    assert_push_clears_tmo_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !rx_timeout);

endmodule

bind irfifo_dma irfifo_dma_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .dma_en     (dma_en),
    .push       (push),
    .pop        (pop),
    .dack       (dack),
    .tc         (tc),
    .count      (count),
    .pop_data   (pop_data),
    .overrun    (overrun),
    .irq        (irq),
    .rx_timeout (rx_timeout),
    .req_act    (req_act)
);

// File: tb/irfifo_dma_tb.sv
`timescale 1ns/1ps
module irfifo_dma_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 0, rx_en = 0, dma_en = 0, dreq_pol = 0;
    logic [5:0]  thresh = 6'd0;
    logic [15:0] bit_period = 16'd2;
    logic        push = 0, pop = 0, dack = 0, tc = 0;
    logic [7:0]  push_data = 8'd0;
    logic [7:0]  pop_data;
    logic [5:0]  count;
    logic        full, overrun, irq, dreq, rx_timeout;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    irfifo_dma u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
        .dma_en(dma_en), .dreq_pol(dreq_pol), .thresh(thresh),
        .bit_period(bit_period), .push(push), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .dack(dack), .tc(tc),
        .count(count), .full(full), .overrun(overrun), .irq(irq),
        .dreq(dreq), .rx_timeout(rx_timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_push(input logic [7:0] v);
        @(negedge clk); push = 1; push_data = v;
        @(negedge clk); push = 0;
    endtask

    task automatic do_pop();
        @(negedge clk); pop = 1;
        @(negedge clk); pop = 0;
    endtask

    task automatic drain();
        while (count != 0) do_pop();
    endtask

    task automatic t_reset();
        chk("R12 count", count, 0);
        chk("R12 overrun", overrun, 0);
        chk("R12 irq", irq, 0);
        chk("R12 dreq inactive low-pol", dreq, 1);
        chk("R12 timeout", rx_timeout, 0);
        chk("R3 pop_data empty", pop_data, 0);
    endtask

    task automatic t_order();
        do_push(8'hA5); do_push(8'h3C); do_push(8'h7E);
        chk("R1 count 3", count, 3);
        chk("R1 head 0", pop_data, 8'hA5); do_pop();
        chk("R1 head 1", pop_data, 8'h3C); do_pop();
        chk("R1 head 2", pop_data, 8'h7E); do_pop();
        chk("R1 empty", count, 0);
    endtask

    task automatic t_overrun();
        @(negedge clk); rx_en = 1; thresh = 6'd32;
        for (int i = 0; i < 32; i++) do_push(8'(i * 3 + 1));
        chk("R1 full", full, 1);
        chk("R1 count 32", count, 32);
        chk("R2 no overrun yet", overrun, 0);
        do_push(8'hFF);
        chk("R2 count kept", count, 32);
        chk("R2 overrun set", overrun, 1);
        for (int i = 0; i < 32; i++) begin
            chk("R2 contents kept", pop_data, (i * 3 + 1) & 8'hFF);
            do_pop();
        end
        chk("R2 overrun sticky", overrun, 1);
        @(negedge clk); rx_en = 0;
        @(negedge clk);
        chk("R10 overrun cleared idle", overrun, 0);
    endtask

    task automatic t_empty();
        do_pop();
        chk("R3 count stays 0", count, 0);
        chk("R3 data 0", pop_data, 0);
    endtask

    task automatic t_rx_irq();
        @(negedge clk); rx_en = 1; thresh = 6'd3;
        do_push(8'h11); do_push(8'h22);
        chk("R4 below threshold", irq, 0);
        do_push(8'h33);
        chk("R6 R4 at threshold irq", irq, 1);
        do_pop();
        chk("R4 back below", irq, 0);
        drain();
        @(negedge clk); rx_en = 0;
    endtask

    task automatic t_tx_irq();
        @(negedge clk); tx_en = 1; rx_en = 1; thresh = 6'd2;
        @(negedge clk);
        chk("R5 empty wants", irq, 1);
        do_push(8'h01);
        chk("R5 count1 wants", irq, 1);
        do_push(8'h02);
        chk("R5 at threshold quiet", irq, 0);
        drain();
        @(negedge clk); tx_en = 0; rx_en = 0;
    endtask

    task automatic t_idle();
        @(negedge clk); thresh = 6'd3; dma_en = 1;
        for (int i = 0; i < 5; i++) do_push(8'(i));
        @(negedge clk); @(negedge clk);
        chk("R10 idle irq", irq, 0);
        chk("R10 idle dreq", dreq, 1);
        drain();
        @(negedge clk); dma_en = 0;
    endtask

    task automatic t_dma_low();
        @(negedge clk); rx_en = 1; dma_en = 1; dreq_pol = 0; thresh = 6'd2;
        do_push(8'h10); do_push(8'h20);
        @(negedge clk);
        chk("R6 irq masked", irq, 0);
        chk("R7 R6 dreq active low", dreq, 0);
        do_pop();
        @(negedge clk);
        chk("R8 held without dack", dreq, 0);
        @(negedge clk); dack = 1;
        @(negedge clk); dack = 0;
        chk("R8 released by dack", dreq, 1);
        drain();
        @(negedge clk); rx_en = 0; dma_en = 0;
    endtask

    task automatic t_dma_high();
        @(negedge clk); tx_en = 1; dma_en = 1; dreq_pol = 1; thresh = 6'd1;
        @(negedge clk); @(negedge clk);
        chk("R7 dreq active high", dreq, 1);
        @(negedge clk); dack = 1; push = 1; push_data = 8'h5A;
        @(negedge clk); dack = 0; push = 0;
        chk("R8 dack release tx", dreq, 0);
        chk("R6 irq masked tx", irq, 0);
        @(negedge clk); tx_en = 0; dma_en = 0;
        drain();
        @(negedge clk); dreq_pol = 0;
    endtask

    task automatic t_tc();
        @(negedge clk); rx_en = 1; dma_en = 1; dreq_pol = 1; thresh = 6'd1;
        do_push(8'h01); do_push(8'h02); do_push(8'h03);
        chk("R9 active before tc", dreq, 1);
        @(negedge clk); dack = 1; tc = 1; pop = 1;
        @(negedge clk); dack = 0; tc = 0; pop = 0;
        chk("R9 forced off", dreq, 0);
        repeat (3) @(negedge clk);
        chk("R9 stays off while wanted", dreq, 0);
        do_pop(); do_pop();
        @(negedge clk);
        do_push(8'h04);
        @(negedge clk);
        chk("R9 rearmed", dreq, 1);
        @(negedge clk); rx_en = 0; dma_en = 0;
        drain();
        @(negedge clk); dreq_pol = 0;
    endtask

    task automatic t_timeout();
        @(negedge clk); rx_en = 1; thresh = 6'd4; bit_period = 16'd2;
        do_push(8'hC1);
        repeat (60) @(negedge clk);
        chk("R11 not yet", rx_timeout, 0);
        repeat (10) @(negedge clk);
        chk("R11 expired", rx_timeout, 1);
        do_push(8'hC2);
        chk("R11 push clears", rx_timeout, 0);
        repeat (70) @(negedge clk);
        chk("R11 expired again", rx_timeout, 1);
        do_pop();
        chk("R11 pop clears", rx_timeout, 0);
        drain();
        @(negedge clk); rx_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_order();
        t_overrun();
        t_empty();
        t_rx_irq();
        t_tx_irq();
        t_idle();
        t_dma_low();
        t_dma_high();
        t_tc();
        t_timeout();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule